// File: doc/BRIEF.md
# Window Watchdog Timer

This block is a bus-programmed watchdog that opens a time window for service instead of accepting service at any moment. Software stores two durations, a closed-window length and an open-window length, and then starts the timer. The timer counts through the closed window, during which a service request counts as a fault. It then counts through the open window, during which a service request restarts the whole sequence. If the open window runs out without service, the block raises a sticky timeout line. Downstream logic uses that line to reset the system.

The control/status register is protected by a one-shot key. A 1 must be written to bit 0 of the key register at offset 0x00 right before each write to the control/status register at offset 0x04. Any write to 0x04 uses up the key, whether or not the key was armed. Service is a rising edge of the stored service bit produced by two guarded writes: one clears the bit and one sets it. The open-window flag is cleared by writing a 1 to it.

Top module: `window_guard`

## Requirements
- R1: After reset, every register (0x00, 0x04, 0x08, 0x0C, 0x10) reads as zero and the timeout output is low.
- R2: A write with bit 0 = 1 to offset 0x00 arms the key, which reads back as bit 0 of 0x00. Any write to 0x04 disarms the key. A write to 0x04 while the key is disarmed changes no stored bit.
- R3: A guarded write to 0x04 with bit 0 = 1, made while the timer is stopped, loads the closed-window count N (at 0x0C) and enters the closed window. On the Nth clock edge after that write, the timer enters the open window and sets the flag at bit 16 of 0x04.
- R4: The open window loaded with count M (at 0x10) raises the timeout on the Mth edge after the window is entered. A count of 0 or 1 gives a timeout on the first edge.
- R5: Service is a guarded write to 0x04 with bit 0 = 1 and bit 8 = 1 while the stored bit 8 is 0 and the timer runs. During the open window, service restarts the closed window, and the timeout stays low.
- R6: Service during a nonzero closed window raises the timeout on the edge of that write.
- R7: With a closed-window count of 0, starting the timer enters the open window at once with the flag set, and service restarts the open window.
- R8: Timeout is sticky: it stays high until a guarded write to 0x04 with bit 0 = 0, which stops the timer and drops timeout on that edge.
- R9: A guarded write to 0x04 with bit 16 = 1 clears the flag; bit 16 = 0 leaves it unchanged.
- R10: Writes to 0x08, 0x0C and 0x10 are ignored while the timer runs; while it is stopped, they are stored and read back.
- R11: Reads of 0x04 return the enable bit at bit 0, the service bit at bit 8 and the flag at bit 16, with zeros elsewhere.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | ADDR_W (5) | Byte offset of register access |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busWrData | input | DATA_W (32) | Write data |
| busRdData | output | DATA_W (32) | Read data for busAddr, combinational |
| timeoutOut | output | 1 | Sticky watchdog expiry / fault |

## Verification
The hardest situation to reach from the ports is a service write landing in an exact window phase, since every service needs four back-to-back bus writes (key, clear, key, set) that all consume clock edges. The stimulus drives those writes on consecutive edges with no idle cycles. It sizes the open window so the four-write sequence falls clearly inside it, and it counts edges from each write to predict when the flag and the timeout change. A separate run places the set write inside a five-cycle closed window to provoke the early-service fault, and a zero closed-window run checks that service immediately after start is legal.

// File: rtl/window_guard_pkg.sv
package window_guard_pkg;

  // register byte offsets; software depends on these positions
  localparam logic [7:0] OFF_KEY    = 8'h00;
  localparam logic [7:0] OFF_CTRL   = 8'h04;
  localparam logic [7:0] OFF_CFG    = 8'h08;
  localparam logic [7:0] OFF_CLOSED = 8'h0C;
  localparam logic [7:0] OFF_OPEN   = 8'h10;

  // control/status bit positions
  localparam int BIT_EN   = 0;
  localparam int BIT_SVC  = 8;
  localparam int BIT_FLAG = 16;

  localparam int NUM_WIN = 2;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_CLOSED,
    PH_OPEN,
    PH_EXPIRED
  } wgPhase_t;

  // control-to-datapath strobes
  typedef struct packed {
    logic clear;
    logic loadClosed;
    logic loadOpen;
    logic decrement;
  } wgStrobe_t;

endpackage

// File: rtl/window_guard_dp.sv
module window_guard_dp
  import window_guard_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  wgStrobe_t        strb,
  input  logic [CNT_W-1:0] closedCnt,
  input  logic [CNT_W-1:0] openCnt,
  output logic             cntLast
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cntQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ <= '0;
    end else if (strb.clear) begin
      cntQ <= '0;
    end else if (strb.loadClosed) begin
      cntQ <= closedCnt;
    end else if (strb.loadOpen) begin
      cntQ <= openCnt;
    end else if (strb.decrement) begin
      cntQ <= cntQ - ONE;
    end
  end

  // a window ends on the edge where the count stands at one (or zero)
  assign cntLast = (cntQ <= ONE);

endmodule

// File: rtl/window_guard_ctrl.sv
module window_guard_ctrl
  import window_guard_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              cntLast,
  output wgStrobe_t         strb,
  output logic              armedQ,
  output logic              enableQ,
  output logic              svcQ,
  output logic              flagQ,
  output logic              timeoutQ,
  output logic [DATA_W-1:0] cfgQ,
  output logic [CNT_W-1:0]  closedCntQ,
  output logic [CNT_W-1:0]  openCntQ
);

  localparam logic [ADDR_W-1:0] A_KEY  = ADDR_W'(OFF_KEY);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(OFF_CFG);
  localparam logic [ADDR_W-1:0] A_WIN [NUM_WIN] = '{ADDR_W'(OFF_CLOSED), ADDR_W'(OFF_OPEN)};

  wgPhase_t phaseQ, phaseNext;
  logic wrKey, wrCtrl, guarded;
  logic wantEn, enRise, disableEv, svcEv, closedZero;
  logic setFlag, setTimeout, restart;
  logic [CNT_W-1:0] winCntQ [NUM_WIN];

  assign wrKey     = busWrEn && (busAddr == A_KEY);
  assign wrCtrl    = busWrEn && (busAddr == A_CTRL);
  assign guarded   = wrCtrl && armedQ;
  assign wantEn    = busWrData[BIT_EN];
  assign enRise    = guarded && wantEn && !enableQ;
  assign disableEv = guarded && !wantEn;
  assign svcEv     = guarded && wantEn && enableQ && busWrData[BIT_SVC] && !svcQ;
  assign closedZero = (winCntQ[0] == '0);
  assign restart   = enRise || (svcEv && phaseQ == PH_OPEN);

  // one-shot key
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armedQ <= 1'b0;
    end else if (wrCtrl) begin
      armedQ <= 1'b0;
    end else if (wrKey) begin
      armedQ <= busWrData[0];
    end
  end

  // guarded control bits
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enableQ <= 1'b0;
      svcQ    <= 1'b0;
    end else if (guarded) begin
      enableQ <= wantEn;
      svcQ    <= busWrData[BIT_SVC];
    end
  end

  // window counts, held while running
  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        winCntQ[w] <= '0;
      end else if (busWrEn && (busAddr == A_WIN[w]) && !enableQ) begin
        winCntQ[w] <= busWrData[CNT_W-1:0];
      end
    end
  end

  assign closedCntQ = winCntQ[0];
  assign openCntQ   = winCntQ[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ <= '0;
    end else if (busWrEn && (busAddr == A_CFG) && !enableQ) begin
      cfgQ <= busWrData;
    end
  end

  // sequencing
  always_comb begin
    strb       = '0;
    phaseNext  = phaseQ;
    setFlag    = 1'b0;
    setTimeout = 1'b0;
    if (disableEv) begin
      strb.clear = 1'b1;
      phaseNext  = PH_IDLE;
    end else if (restart) begin
      if (closedZero) begin
        strb.loadOpen = 1'b1;
        setFlag       = 1'b1;
        phaseNext     = PH_OPEN;
      end else begin
        strb.loadClosed = 1'b1;
        phaseNext       = PH_CLOSED;
      end
    end else if (svcEv && phaseQ == PH_CLOSED) begin
      setTimeout = 1'b1;
      phaseNext  = PH_EXPIRED;
    end else begin
      unique case (phaseQ)
        PH_CLOSED: begin
          if (cntLast) begin
            strb.loadOpen = 1'b1;
            setFlag       = 1'b1;
            phaseNext     = PH_OPEN;
          end else begin
            strb.decrement = 1'b1;
          end
        end
        PH_OPEN: begin
          if (cntLast) begin
            setTimeout = 1'b1;
            phaseNext  = PH_EXPIRED;
          end else begin
            strb.decrement = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseQ <= PH_IDLE;
    end else begin
      phaseQ <= phaseNext;
    end
  end

  // window flag: set by the sequencer, cleared by writing one
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagQ <= 1'b0;
    end else if (setFlag) begin
      flagQ <= 1'b1;
    end else if (guarded && busWrData[BIT_FLAG]) begin
      flagQ <= 1'b0;
    end
  end

  // sticky timeout
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timeoutQ <= 1'b0;
    end else if (disableEv) begin
      timeoutQ <= 1'b0;
    end else if (setTimeout) begin
      timeoutQ <= 1'b1;
    end
  end

endmodule

// File: rtl/window_guard.sv
module window_guard
  import window_guard_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  output logic              timeoutOut
);

  wgStrobe_t         strb;
  logic              cntLast;
  logic              armedQ, enableQ, svcQ, flagQ, timeoutQ;
  logic [DATA_W-1:0] cfgQ;
  logic [CNT_W-1:0]  closedCntQ, openCntQ;
  logic [DATA_W-1:0] statusWord;

  window_guard_ctrl #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .cntLast(cntLast), .strb(strb),
    .armedQ(armedQ), .enableQ(enableQ), .svcQ(svcQ), .flagQ(flagQ),
    .timeoutQ(timeoutQ), .cfgQ(cfgQ), .closedCntQ(closedCntQ),
    .openCntQ(openCntQ)
  );

  window_guard_dp #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .closedCnt(closedCntQ),
    .openCnt(openCntQ), .cntLast(cntLast)
  );

  always_comb begin
    statusWord           = '0;
    statusWord[BIT_EN]   = enableQ;
    statusWord[BIT_SVC]  = svcQ;
    statusWord[BIT_FLAG] = flagQ;
  end

  always_comb begin
    unique case (busAddr)
      ADDR_W'(OFF_KEY):    busRdData = DATA_W'(armedQ);
      ADDR_W'(OFF_CTRL):   busRdData = statusWord;
      ADDR_W'(OFF_CFG):    busRdData = cfgQ;
      ADDR_W'(OFF_CLOSED): busRdData = DATA_W'(closedCntQ);
      ADDR_W'(OFF_OPEN):   busRdData = DATA_W'(openCntQ);
      default:             busRdData = '0;
    endcase
  end

  assign timeoutOut = timeoutQ;

endmodule

// File: rtl/window_guard_chk.sv
module window_guard_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5,
  parameter int CNT_W  = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWrEn,
  input logic [DATA_W-1:0] busWrData,
  input logic              armedQ,
  input logic              enableQ,
  input logic              timeoutOut,
  input logic [CNT_W-1:0]  closedCntQ
);

  logic ctrlWr;
  assign ctrlWr = busWrEn && (busAddr == ADDR_W'(8'h04));

  assert_key_consumed_R2: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWr |=> !armedQ);

  assert_locked_write_R2: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && !armedQ) |=> $stable(enableQ));

  assert_timeout_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    (timeoutOut && !(ctrlWr && !busWrData[0])) |=> timeoutOut);

  assert_stop_clears_R8: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && armedQ && !busWrData[0]) |=> (!timeoutOut && !enableQ));

  assert_timeout_needs_run_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timeoutOut) |-> enableQ);

  assert_count_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (enableQ && busWrEn && busAddr == ADDR_W'(8'h0C)) |=> $stable(closedCntQ));

endmodule

bind window_guard window_guard_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
  .busWrData(busWrData), .armedQ(armedQ), .enableQ(enableQ),
  .timeoutOut(timeoutOut), .closedCntQ(closedCntQ)
);

// File: tb/window_guard_bench.sv
module window_guard_bench;
  timeunit 1ns;
  timeprecision 10ps;

  localparam int DATA_W = 32;
  localparam int ADDR_W = 5;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic              busWrEn = 1'b0;
  logic [DATA_W-1:0] busWrData = '0;
  logic [DATA_W-1:0] busRdData;
  logic              timeoutOut;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [DATA_W:0] expQ [$];
  string           tagQ [$];
  event            sampleEv;

  always #5 clk = ~clk;

  window_guard u_window_guard (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .timeoutOut(timeoutOut)
  );

  // monitor: pops expectations and compares against the ports
  initial begin
    forever begin
      @(sampleEv);
      #0.1;
      if (expQ.size() > 0) begin
        logic [DATA_W:0] exp;
        string tag;
        exp = expQ.pop_front();
        tag = tagQ.pop_front();
        checks++;
        if ({timeoutOut, busRdData} !== exp) begin
          errors++;
          $display("FAIL %s: timeout/rdata actual %b/%h expected %b/%h",
                   tag, timeoutOut, busRdData, exp[DATA_W], exp[DATA_W-1:0]);
        end
      end
    end
  end

  // driver side: queue an expectation for a read of addr
  task automatic expect_rd(input string tag, input logic [7:0] addr,
                           input logic [31:0] data, input logic to);
    busAddr = ADDR_W'(addr);
    expQ.push_back({to, data});
    tagQ.push_back(tag);
    ->sampleEv;
    #0.2;
  endtask

  // one bus write on the next rising edge; called just after a falling edge
  task automatic wr(input logic [7:0] addr, input logic [31:0] data);
    busAddr   = ADDR_W'(addr);
    busWrData = data;
    busWrEn   = 1'b1;
    @(negedge clk);
    busWrEn   = 1'b0;
  endtask

  task automatic guarded_wr(input logic [31:0] data);
    wr(8'h00, 32'h1);
    wr(8'h04, data);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run hung, actual running expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    expect_rd("R1 key", 8'h00, 32'h0, 1'b0);
    expect_rd("R1 ctrl", 8'h04, 32'h0, 1'b0);
    expect_rd("R1 cfg", 8'h08, 32'h0, 1'b0);
    expect_rd("R1 closed", 8'h0C, 32'h0, 1'b0);
    expect_rd("R1 open", 8'h10, 32'h0, 1'b0);

    // R2 locked write ignored
    wr(8'h04, 32'h1);
    expect_rd("R2 locked", 8'h04, 32'h0, 1'b0);

    // R10 stores while stopped
    wr(8'h0C, 32'd3);
    wr(8'h10, 32'd20);
    wr(8'h08, 32'hA5);
    expect_rd("R10 closed", 8'h0C, 32'd3, 1'b0);
    expect_rd("R10 open", 8'h10, 32'd20, 1'b0);
    expect_rd("R10 cfg", 8'h08, 32'hA5, 1'b0);

    // R2 arm, R3 start
    wr(8'h00, 32'h1);
    expect_rd("R2 armed", 8'h00, 32'h1, 1'b0);
    wr(8'h04, 32'h1);
    expect_rd("R2 consumed", 8'h00, 32'h0, 1'b0);
    expect_rd("R11 running", 8'h04, 32'h1, 1'b0);
    repeat (2) @(negedge clk);
    expect_rd("R3 closed", 8'h04, 32'h1, 1'b0);
    @(negedge clk);
    expect_rd("R3 open flag", 8'h04, 32'h10001, 1'b0);

    // R9 clear flag, R5 service in open window
    guarded_wr(32'h10001);
    expect_rd("R9 flag cleared", 8'h04, 32'h1, 1'b0);
    guarded_wr(32'h101);
    expect_rd("R5 service", 8'h04, 32'h101, 1'b0);
    repeat (22) @(negedge clk);
    expect_rd("R4 before expiry", 8'h04, 32'h10101, 1'b0);
    @(negedge clk);
    expect_rd("R4 expiry", 8'h04, 32'h10101, 1'b1);
    repeat (5) @(negedge clk);
    expect_rd("R8 sticky", 8'h04, 32'h10101, 1'b1);

    // R10 writes ignored while running; R2 locked flag clear
    wr(8'h0C, 32'd9);
    wr(8'h10, 32'd9);
    expect_rd("R10 closed held", 8'h0C, 32'd3, 1'b1);
    expect_rd("R10 open held", 8'h10, 32'd20, 1'b1);
    wr(8'h04, 32'h10000);
    expect_rd("R2 locked clear", 8'h04, 32'h10101, 1'b1);

    // R8 stop, R9 zero leaves flag
    guarded_wr(32'h0);
    expect_rd("R8 stop", 8'h04, 32'h10000, 1'b0);

    // R6 early service
    wr(8'h0C, 32'd5);
    guarded_wr(32'h10000);
    expect_rd("R9 clear", 8'h04, 32'h0, 1'b0);
    guarded_wr(32'h1);
    guarded_wr(32'h101);
    expect_rd("R6 early", 8'h04, 32'h101, 1'b1);
    guarded_wr(32'h10000);
    expect_rd("R8 stop2", 8'h04, 32'h0, 1'b0);

    // R7 zero closed window, R4 count of one
    wr(8'h0C, 32'd0);
    wr(8'h10, 32'd1);
    guarded_wr(32'h1);
    expect_rd("R7 direct open", 8'h04, 32'h10001, 1'b0);
    @(negedge clk);
    expect_rd("R4 count one", 8'h04, 32'h10001, 1'b1);
    guarded_wr(32'h10000);
    expect_rd("R8 stop3", 8'h04, 32'h0, 1'b0);

    // R7 service right after start
    wr(8'h10, 32'd6);
    guarded_wr(32'h1);
    guarded_wr(32'h101);
    expect_rd("R7 service ok", 8'h04, 32'h10101, 1'b0);
    repeat (5) @(negedge clk);
    expect_rd("R7 reopened", 8'h04, 32'h10101, 1'b0);
    @(negedge clk);
    expect_rd("R7 expiry", 8'h04, 32'h10101, 1'b1);

    #1;
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule